// File: doc/BRIEF.md
# Prescaled SCL Timing Generator

This block produces the clock waveform for an I2C bus master. A programmable divider turns the functional clock into a module time base, aimed at about 12 MHz. For example, a 12 MHz functional clock uses a divide value of 0 and a 19.2 MHz clock uses 1. The low and high halves of each SCL period are then counted separately on that time base. Each half has its own programmable count, and the block adds a fixed offset of seven time-base ticks to each. With suitable counts this gives the 100 kHz standard rate and the 400 kHz fast rate.

Besides the SCL level, the block gives two single-cycle strobes. One marks the middle of the low half, where a master changes SDA. The other marks the middle of the high half, where SDA is sampled. The block watches the real bus line. While the line is still held low during the high half, counting stops, so a slave can stretch the clock. The three configuration registers may be rewritten at any time. A new value only takes effect at the next boundary between halves. START and STOP sequencing belong to the surrounding controller.

Top module: `scl_phase_gen`

## Requirements
- R1: Under synchronous active-low reset, `scl_out` is 1 (released), both strobes are 0 and all three registers read back 0.
- R2: Registers sit at word addresses 0 (divide value), 1 (low count) and 2 (high count). Each is REG_W bits wide, written when `cfg_we` is high and read back combinationally on `cfg_rdata` at the address on `cfg_addr`. Address 3 reads 0, and a write to it changes none of the three registers.
- R3: The phase time base advances once every divide+1 clock cycles.
- R4: Each low half holds `scl_out` at 0 for exactly (low+7)*(divide+1) clock cycles.
- R5: Each high half releases `scl_out` for (high+7)*(divide+1) cycles during which `scl_in` is high.
- R6: `strb_low_mid` is high for exactly one cycle per low half, in cycle (floor((low+7)/2)+1)*(divide+1) of that half (counting from 1), and never while `scl_out` is 1.
- R7: `strb_high_mid` is high for exactly one cycle per high half, in cycle (floor((high+7)/2)+1)*(divide+1) counted from the first cycle `scl_in` is high, and only while both `scl_out` and `scl_in` are 1.
- R8: During a high half, every cycle in which `scl_in` is low freezes both the divider and the phase count. A stretch of X cycles lengthens the low level seen on the bus by X cycles and leaves the following high level and its strobe timing unchanged.
- R9: With `gen_en` low, `scl_out` is 1 from the next clock edge on and no strobe fires. `scl_out` falls on the first edge that registers `gen_en` high, starting a full low half.
- R10: A register written while the generator runs does not alter the current half. Values are taken up at the next boundary between halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous reset, active low |
| gen_en | input | 1 | Run the generator; low releases SCL |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register word address |
| cfg_wdata | input | REG_W | Register write data |
| cfg_rdata | output | REG_W | Register read data for `cfg_addr` |
| scl_in | input | 1 | Sensed level of the bus clock line |
| scl_out | output | 1 | SCL drive: 0 pulls low, 1 releases |
| strb_low_mid | output | 1 | One-cycle strobe in the middle of the low half |
| strb_high_mid | output | 1 | One-cycle strobe in the middle of the high half |

## Verification
The bench measures every half-period on the bus line and the position of each strobe, using divide values 0, 1 and 2. The scale factor of divide+1 is therefore tested apart from the offset of seven. A design that dropped the offset, or divided by the value rather than by value+1, would return half-periods that are short by a fixed amount or scaled wrong. A slave model holds the line for several cycles after release. A design that kept the divider running while frozen would shorten the next high level or move its strobe. Registers are rewritten in the middle of a low half. A design that took them up at once would lengthen the current half instead of the next one.

// File: rtl/scl_gen_pkg.sv
// Shared definitions for the SCL timing generator.
// Assumes: register word indices are fixed by the register decode.
package scl_gen_pkg;
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    localparam int unsigned REG_PSC  = 0;
    localparam int unsigned REG_LOW  = 1;
    localparam int unsigned REG_HIGH = 2;
    localparam int unsigned NUM_REGS = 3;
endpackage

// File: rtl/scl_cfg_regs.sv
// Holds the divide value and the low/high counts written over the
// configuration port. Reads are combinational.
// Assumes: addresses at or above NUM_REGS are unmapped.
module scl_cfg_regs
    import scl_gen_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int REG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic [REG_W-1:0]  psc_reg,
    output logic [REG_W-1:0]  low_reg,
    output logic [REG_W-1:0]  high_reg
);
    logic [NUM_REGS-1:0][REG_W-1:0] regs_q;

    // Write decode: only a matching mapped address updates its register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (cfg_addr == ADDR_W'(i)) regs_q[i] <= cfg_wdata;
            end
        end
    end

    // Read mux: unmapped addresses return zero.
    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (cfg_addr == ADDR_W'(i)) cfg_rdata = regs_q[i];
        end
    end

    assign psc_reg  = regs_q[REG_PSC];
    assign low_reg  = regs_q[REG_LOW];
    assign high_reg = regs_q[REG_HIGH];

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_chk
        assert_unmapped_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr >= ADDR_W'(NUM_REGS)) |=> $stable(regs_q[gi]));
        assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr == ADDR_W'(gi)) |=> (regs_q[gi] == $past(cfg_wdata)));
    end
endmodule

// File: rtl/scl_prescaler.sv
// Divides the functional clock into a one-cycle time-base tick every
// div+1 cycles of run. Holding run low freezes the divider in place.
// Assumes: div only changes in the cycle after a tick or while cleared.
module scl_prescaler #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [REG_W-1:0] div,
    output logic             tick
);
    logic [REG_W-1:0] pcnt_q;

    assign tick = run && (pcnt_q == div);

    // Divider count: wraps on tick, holds while not running.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pcnt_q <= '0;
        end else if (run) begin
            pcnt_q <= tick ? '0 : pcnt_q + 1'b1;
        end
    end

    assert_div_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (pcnt_q <= div));
    assert_tick_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pcnt_q == '0));
endmodule

// File: rtl/scl_phase_ctr.sv
// Counts the low and high halves of SCL on the time-base tick, adding a
// fixed offset to each programmed count. Takes up new register values
// only at a half boundary or while disabled. Freezes when the sensed line
// is low during the high half.
// Assumes: en_q is a registered enable; scl_in is synchronous to clk.
module scl_phase_ctr
    import scl_gen_pkg::*;
#(
    parameter int REG_W     = 8,
    parameter int PHASE_OFS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_q,
    input  logic             tick,
    input  logic             scl_in,
    input  logic [REG_W-1:0] psc_reg,
    input  logic [REG_W-1:0] low_reg,
    input  logic [REG_W-1:0] high_reg,
    output logic [REG_W-1:0] act_psc,
    output logic             run,
    output logic             scl_out,
    output logic             mid_low,
    output logic             mid_high
);
    localparam int LEN_W = $clog2((1 << REG_W) + PHASE_OFS);

    phase_e           phase_q;
    logic [LEN_W-1:0] cnt_q;
    logic [REG_W-1:0] act_psc_q, act_low_q, act_high_q;
    logic [LEN_W-1:0] cur_len, half_len;
    logic             last, done, mid;

    assign cur_len  = LEN_W'(phase_q == PH_LOW ? act_low_q : act_high_q)
                    + LEN_W'(PHASE_OFS);
    assign half_len = cur_len >> 1;
    assign last     = (cnt_q == cur_len - LEN_W'(1));
    assign done     = tick && last;
    assign mid      = tick && (cnt_q == half_len);

    // Time base runs unless the bus is stretched during the high half.
    assign run      = en_q && !(phase_q == PH_HIGH && !scl_in);
    assign act_psc  = act_psc_q;
    assign scl_out  = !en_q || (phase_q == PH_HIGH);
    assign mid_low  = mid && (phase_q == PH_LOW);
    assign mid_high = mid && (phase_q == PH_HIGH);

    // Half sequencing and register take-up at boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_LOW;
            cnt_q      <= '0;
            act_psc_q  <= '0;
            act_low_q  <= '0;
            act_high_q <= '0;
        end else if (!en_q) begin
            phase_q    <= PH_LOW;
            cnt_q      <= '0;
            act_psc_q  <= psc_reg;
            act_low_q  <= low_reg;
            act_high_q <= high_reg;
        end else if (done) begin
            phase_q    <= (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
            cnt_q      <= '0;
            act_psc_q  <= psc_reg;
            act_low_q  <= low_reg;
            act_high_q <= high_reg;
        end else if (tick) begin
            cnt_q      <= cnt_q + 1'b1;
        end
    end

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |-> (cnt_q < cur_len));
    assert_stretch_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && phase_q == PH_HIGH && !scl_in) |=> ($stable(cnt_q) && phase_q == PH_HIGH));
    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !done) |=> ($stable(act_low_q) && $stable(act_high_q) && $stable(act_psc_q)));
endmodule

// File: rtl/scl_phase_gen.sv
// Top of the SCL timing generator: register bank, divider and half
// counter. Produces the SCL drive level and the mid-half strobes.
// Assumes: scl_in already synchronised to clk by the pad logic.
module scl_phase_gen #(
    parameter int ADDR_W    = 2,
    parameter int REG_W     = 8,
    parameter int PHASE_OFS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_en,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              scl_in,
    output logic              scl_out,
    output logic              strb_low_mid,
    output logic              strb_high_mid
);
    logic             en_q;
    logic             tick, run;
    logic [REG_W-1:0] psc_reg, low_reg, high_reg, act_psc;

    // Registered enable so every counter starts from a clean edge.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= gen_en;
    end

    scl_cfg_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .psc_reg   (psc_reg),
        .low_reg   (low_reg),
        .high_reg  (high_reg)
    );

    scl_prescaler #(.REG_W(REG_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!en_q),
        .run   (run),
        .div   (act_psc),
        .tick  (tick)
    );

    scl_phase_ctr #(.REG_W(REG_W), .PHASE_OFS(PHASE_OFS)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_q     (en_q),
        .tick     (tick),
        .scl_in   (scl_in),
        .psc_reg  (psc_reg),
        .low_reg  (low_reg),
        .high_reg (high_reg),
        .act_psc  (act_psc),
        .run      (run),
        .scl_out  (scl_out),
        .mid_low  (strb_low_mid),
        .mid_high (strb_high_mid)
    );

    assert_mid_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        strb_low_mid |-> !scl_out);
    assert_mid_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        strb_high_mid |-> (scl_out && scl_in));
    assert_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> (scl_out && !strb_low_mid && !strb_high_mid));
endmodule

// File: tb/tb_scl_phase_gen.sv
`timescale 1ns/1ps
module tb_scl_phase_gen;
    localparam int ADDR_W = 2;
    localparam int REG_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              gen_en = 1'b0;
    logic              cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [REG_W-1:0]  cfg_wdata = '0;
    logic [REG_W-1:0]  cfg_rdata;
    logic              scl_in, scl_out, strb_low_mid, strb_high_mid;
    logic              hold = 1'b0;
    logic              stretch_req = 1'b0;
    int                stretch_x = 0;
    int                hold_rem = 0;

    int tests = 0;
    int fails = 0;

    typedef struct {
        bit    lvl;
        int    len;
        int    pos;
        string ltag;
        string stag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    assign scl_in = scl_out & ~hold;

    scl_phase_gen #(.ADDR_W(ADDR_W), .REG_W(REG_W)) dut (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .scl_in(scl_in), .scl_out(scl_out),
        .strb_low_mid(strb_low_mid), .strb_high_mid(strb_high_mid)
    );

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drv_step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(int a, int d);
        drv_step();
        cfg_we = 1'b1; cfg_addr = ADDR_W'(a); cfg_wdata = REG_W'(d);
        drv_step();
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(int a, int exp, string req);
        drv_step();
        cfg_addr = ADDR_W'(a);
        @(negedge clk);
        chk(req, int'(cfg_rdata), exp);
    endtask

    task automatic push(bit lvl, int len, int pos, string lt, string st);
        item_t it;
        it.lvl = lvl; it.len = len; it.pos = pos; it.ltag = lt; it.stag = st;
        sb.push_back(it);
    endtask

    // Slave model: holds the line low for x extra cycles after release.
    always @(posedge clk) begin
        #1;
        if (stretch_req && scl_out == 1'b0 && !hold) begin
            hold = 1'b1;
            hold_rem = stretch_x + 1;
            stretch_req = 1'b0;
        end else if (hold && scl_out == 1'b1) begin
            hold_rem--;
            if (hold_rem == 0) hold = 1'b0;
        end
    end

    // Monitor: measures each level run of the bus line and strobe positions.
    bit prev_s = 1'b1;
    bit armed = 1'b0;
    int run_len = 0, nlow = 0, nhigh = 0, posl = 0, posh = 0;
    always @(negedge clk) begin
        bit s;
        s = scl_in;
        if (!rst_n || !gen_en) begin
            armed = 1'b0;
            run_len = 0;
        end else if (s == prev_s) begin
            run_len++;
        end else begin
            if (armed && sb.size() != 0) begin
                item_t e;
                e = sb.pop_front();
                chk(e.ltag, int'(prev_s), int'(e.lvl));
                chk(e.ltag, run_len, e.len);
                if (e.lvl == 1'b0) begin
                    chk(e.stag, nlow, 1);
                    chk(e.stag, posl, e.pos);
                    chk(e.stag, nhigh, 0);
                end else begin
                    chk(e.stag, nhigh, 1);
                    chk(e.stag, posh, e.pos);
                    chk(e.stag, nlow, 0);
                end
            end
            armed = 1'b1;
            run_len = 1;
            nlow = 0; nhigh = 0; posl = 0; posh = 0;
        end
        if (armed) begin
            if (strb_low_mid)  begin nlow++;  posl = run_len; end
            if (strb_high_mid) begin nhigh++; posh = run_len; end
        end
        prev_s = s;
    end

    // Driver: program, enable, queue expected runs, wait, disable, check idle.
    task automatic run_case(int psc, int lo, int hi, int x, bit mid, int nlo, int nhi);
        int q, l0, h0, l1, h1;
        string lt, ht;
        q  = psc + 1;
        l0 = lo + 7; h0 = hi + 7;
        l1 = (mid ? nlo : lo) + 7;
        h1 = (mid ? nhi : hi) + 7;
        lt = (psc > 0) ? "R4 R3" : "R4";
        ht = (psc > 0) ? "R5 R3" : "R5";
        wr(0, psc); wr(1, lo); wr(2, hi);
        push(1'b0, l0 * q + x, (l0 / 2 + 1) * q, (x > 0) ? "R8" : lt, "R6");
        push(1'b1, h1 * q, (h1 / 2 + 1) * q, (x > 0) ? "R8" : (mid ? "R10" : ht), "R7");
        push(1'b0, l1 * q, (l1 / 2 + 1) * q, mid ? "R10" : lt, "R6");
        push(1'b1, h1 * q, (h1 / 2 + 1) * q, mid ? "R10" : ht, "R7");
        if (x > 0) begin
            stretch_x = x;
            stretch_req = 1'b1;
        end
        drv_step();
        gen_en = 1'b1;
        @(negedge clk);
        chk("R9", int'(scl_out), 1);
        @(negedge clk);
        chk("R9", int'(scl_out), 0);
        if (mid) begin
            wr(1, nlo);
            wr(2, nhi);
        end
        while (sb.size() != 0) @(negedge clk);
        drv_step();
        gen_en = 1'b0;
        repeat (2) @(negedge clk);
        begin
            int hi_seen, strobes;
            hi_seen = 0; strobes = 0;
            for (int k = 0; k < 16; k++) begin
                @(negedge clk);
                if (scl_out) hi_seen++;
                if (strb_low_mid || strb_high_mid) strobes++;
            end
            chk("R9", hi_seen, 16);
            chk("R9", strobes, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        drv_step();
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", int'(scl_out), 1);
        chk("R1", int'(strb_low_mid) + int'(strb_high_mid), 0);
        rd_chk(0, 0, "R1");
        rd_chk(1, 0, "R1");
        rd_chk(2, 0, "R1");

        // R2: register map, readback, unmapped address
        wr(0, 8'h5A); wr(1, 8'hC3); wr(2, 8'h0F);
        rd_chk(0, 8'h5A, "R2");
        rd_chk(1, 8'hC3, "R2");
        rd_chk(2, 8'h0F, "R2");
        wr(3, 8'hFF);
        rd_chk(0, 8'h5A, "R2");
        rd_chk(1, 8'hC3, "R2");
        rd_chk(2, 8'h0F, "R2");
        rd_chk(3, 0, "R2");

        // R4 R5 R6 R7: undivided time base
        run_case(0, 3, 5, 0, 1'b0, 0, 0);
        // R3: divide by two
        run_case(1, 0, 2, 0, 1'b0, 0, 0);
        // R8: divide by three with a six-cycle stretch
        run_case(2, 5, 1, 6, 1'b0, 0, 0);
        // R10: counts rewritten during the first low half
        run_case(0, 3, 5, 0, 1'b1, 9, 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule